// File: doc/BRIEF.md
# Interrupt Status and Enable Unit

This unit gathers single-cycle event pulses from an SD/eMMC host's command and data engines into a sticky status register. Eight of the status bits, one per data lane, record receive CRC failures. The next eight bits record the single-bit events: transmit CRC error, descriptor error, response CRC error, response timeout, descriptor timeout, chain completion, response received and card interrupt. The status register is ANDed with an enable register, and a single registered, level-sensitive interrupt line is raised while that overlap is nonzero.

Software reaches both registers through a small register port. A status read also returns the live busy level of the engines in the top bit. A status write clears every bit written as one and leaves bits written as zero unchanged. The enable register can be read and written, but only its low fourteen bits are implemented. Status bits are set whether or not they are enabled. Enabling a bit that is already set therefore raises the interrupt straight away.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status register, the enable register, the interrupt line and the read data are all zero.
- R2: A pulse on lane input i of `lane_crc_err` sets status bit i, and the bit stays set until it is cleared by software.
- R3: The single-bit events set these status bits: 8 transmit CRC error, 9 descriptor error, 10 response CRC error, 11 response timeout, 12 descriptor timeout, 13 chain done, 14 response seen, 15 card interrupt.
- R4: A write to address 0 (status) clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R5: If an event arrives in the same cycle as a clear of its bit, the bit stays set.
- R6: A write to address 1 (enable) stores `reg_wdata & 0x3FFF`. Enable bits 14 and up always read as 0, so status bits 14 and 15 never raise the interrupt.
- R7: `irq` is registered. After each clock edge it equals the OR of (status AND enable) as held before that edge.
- R8: Status bits latch while disabled. An enable written in a later cycle raises `irq` one cycle after the enable write takes effect.
- R9: A status read returns the live `busy` level in bit 31 and zeros in bits 30..16. Bit 31 is not sticky, and writing to it has no effect.
- R10: `reg_rdata` is loaded on an edge where `reg_rd` is high, with the value the selected register held before that edge. Address 0 selects status, address 1 selects enable, and any other address returns 0. The value holds while `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lane_crc_err | input | LANES | Per-lane receive CRC error pulses |
| tx_crc_err | input | 1 | Transmit CRC error pulse |
| desc_err | input | 1 | Descriptor error pulse |
| rsp_crc_err | input | 1 | Response CRC error pulse |
| rsp_timeout | input | 1 | Response timeout pulse |
| desc_timeout | input | 1 | Descriptor timeout pulse |
| chain_done | input | 1 | End of descriptor chain pulse |
| rsp_seen | input | 1 | Response received pulse |
| card_irq | input | 1 | Card interrupt pulse |
| busy | input | 1 | Live busy level of the engines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register select (0 status, 1 enable) |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Registered read data |
| irq | output | 1 | Level interrupt line |

## Verification
An event sampled at edge k shows in status at edge k. A read strobed at edge k+1 returns that status, and `irq` rises at edge k+1 when the bit is enabled. An enable or clear write at edge j changes `irq` at edge j+1. The bench holds a behavioural model that advances at the same edges as the design. It compares `irq` and `reg_rdata` in the middle of every cycle, where neither is changing, and the directed checks sample at the same point on the cycle each of these rules names.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1
  } reg_sel_e;

  // next sticky status: clears applied first, fresh events win
  function automatic logic [15:0] f_sticky_next(input logic [15:0] cur,
                                                input logic [15:0] clr,
                                                input logic [15:0] ev);
    return (cur & ~clr) | ev;
  endfunction

  // any enabled bit pending
  function automatic logic f_pending(input logic [15:0] stat,
                                     input logic [15:0] en);
    return |(stat & en);
  endfunction

endpackage

// File: rtl/irqs_status.sv
module irqs_status #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] clr,
  output logic [N-1:0] stat_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         stat_q[i] <= 1'b0;
      else if (ev[i])  stat_q[i] <= 1'b1;
      else if (clr[i]) stat_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irqs_enable.sv
module irqs_enable #(
  parameter int          N    = 16,
  parameter logic [N-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst)     en_q <= '0;
    else if (we) en_q <= wdata & KEEP;
  end
endmodule

// File: rtl/irqs_line.sv
module irqs_line #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] stat,
  input  logic [N-1:0] en,
  output logic         irq_q
);
  logic pend;
  assign pend = |(stat & en);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= pend;
  end
endmodule

// File: rtl/irqs_readback.sv
module irqs_readback #(
  parameter int N  = 16,
  parameter int DW = 32,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [N-1:0]  stat,
  input  logic [N-1:0]  en,
  input  logic          busy,
  output logic [DW-1:0] rdata_q
);
  import irqs_pkg::*;
  localparam int BUSY_POS = DW - 1;

  logic [DW-1:0] word;
  always_comb begin
    word = '0;
    if (addr == AW'(SEL_STATUS)) begin
      word[N-1:0]    = stat;
      word[BUSY_POS] = busy;
    end else if (addr == AW'(SEL_ENABLE)) begin
      word[N-1:0] = en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= word;
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int          LANES   = 8,
  parameter int          DW      = 32,
  parameter int          AW      = 2,
  parameter logic [31:0] EN_IMPL = 32'h0000_3FFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] lane_crc_err,
  input  logic             tx_crc_err,
  input  logic             desc_err,
  input  logic             rsp_crc_err,
  input  logic             rsp_timeout,
  input  logic             desc_timeout,
  input  logic             chain_done,
  input  logic             rsp_seen,
  input  logic             card_irq,
  input  logic             busy,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq
);
  import irqs_pkg::*;
  localparam int MISC = 8;
  localparam int N    = LANES + MISC;
  localparam logic [N-1:0] EN_KEEP = EN_IMPL[N-1:0];

  // named internal events (also observed by the checker)
  logic [N-1:0] ev_vec;
  logic [N-1:0] clr_vec;
  logic [N-1:0] stat_vec;
  logic [N-1:0] en_vec;
  logic         en_we;

  assign ev_vec  = {card_irq, rsp_seen, chain_done, desc_timeout,
                    rsp_timeout, rsp_crc_err, desc_err, tx_crc_err, lane_crc_err};
  assign clr_vec = (reg_wr && reg_addr == AW'(SEL_STATUS)) ? reg_wdata[N-1:0] : '0;
  assign en_we   = reg_wr && reg_addr == AW'(SEL_ENABLE);

  irqs_status #(.N(N)) u_status (
    .clk(clk), .rst(rst), .ev(ev_vec), .clr(clr_vec), .stat_q(stat_vec));

  irqs_enable #(.N(N), .KEEP(EN_KEEP)) u_enable (
    .clk(clk), .rst(rst), .we(en_we), .wdata(reg_wdata[N-1:0]), .en_q(en_vec));

  irqs_line #(.N(N)) u_line (
    .clk(clk), .rst(rst), .stat(stat_vec), .en(en_vec), .irq_q(irq));

  irqs_readback #(.N(N), .DW(DW), .AW(AW)) u_rb (
    .clk(clk), .rst(rst), .rd(reg_rd), .addr(reg_addr), .stat(stat_vec),
    .en(en_vec), .busy(busy), .rdata_q(reg_rdata));
endmodule

// File: rtl/irqs_chk.sv
module irqs_chk #(
  parameter int          N    = 16,
  parameter int          DW   = 32,
  parameter int          AW   = 2,
  parameter logic [N-1:0] KEEP = '1
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  ev_vec,
  input logic [N-1:0]  clr_vec,
  input logic [N-1:0]  stat_vec,
  input logic [N-1:0]  en_vec,
  input logic          irq,
  input logic          busy,
  input logic          reg_rd,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_rdata
);
  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~stat_vec & $past(stat_vec & ~clr_vec)) == '0));

  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    ((clr_vec & ~ev_vec) != '0) |=> ((stat_vec & $past(clr_vec & ~ev_vec)) == '0));

  p_event_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (ev_vec != '0) |=> ((stat_vec & $past(ev_vec)) == $past(ev_vec)));

  p_en_mask_r6: assert property (@(posedge clk) disable iff (rst)
    ((en_vec & ~KEEP) == '0));

  p_irq_rise_r7: assert property (@(posedge clk) disable iff (rst)
    ((stat_vec & en_vec) != '0) |=> irq);

  p_irq_fall_r7: assert property (@(posedge clk) disable iff (rst)
    ((stat_vec & en_vec) == '0) |=> !irq);

  p_busy_live_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == '0) |=> (reg_rdata[DW-1] == $past(busy)));

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
endmodule

bind irq_status_unit irqs_chk #(.N(N), .DW(DW), .AW(AW), .KEEP(EN_KEEP)) u_chk (
  .clk(clk), .rst(rst), .ev_vec(ev_vec), .clr_vec(clr_vec), .stat_vec(stat_vec),
  .en_vec(en_vec), .irq(irq), .busy(busy), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata));

// File: tb/irq_status_unit_bench.sv
module irq_status_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  lane_crc_err = '0;
  logic [7:0]  misc = '0; // {card, rsp_seen, chain_done, desc_to, rsp_to, rsp_crc, desc_err, tx_crc}
  logic        busy = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int    n_chk = 0, n_bad = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_unit u_irq_status_unit (
    .clk(clk), .rst(rst), .lane_crc_err(lane_crc_err),
    .tx_crc_err(misc[0]), .desc_err(misc[1]), .rsp_crc_err(misc[2]),
    .rsp_timeout(misc[3]), .desc_timeout(misc[4]), .chain_done(misc[5]),
    .rsp_seen(misc[6]), .card_irq(misc[7]), .busy(busy),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  // behavioural reference model
  logic [15:0] m_stat = '0, m_en = '0;
  logic        m_irq = 1'b0;
  logic [31:0] m_rdata = '0;

  always @(posedge clk) begin
    logic [15:0] clr;
    logic        pend;
    if (rst) begin
      m_stat = '0; m_en = '0; m_irq = 1'b0; m_rdata = '0;
    end else begin
      pend = (m_stat & m_en) != 16'h0;
      if (reg_rd) begin
        if (reg_addr == 2'd0)      m_rdata = {busy, 15'h0, m_stat};
        else if (reg_addr == 2'd1) m_rdata = {16'h0, m_en};
        else                       m_rdata = 32'h0;
      end
      clr = (reg_wr && reg_addr == 2'd0) ? reg_wdata[15:0] : 16'h0;
      for (int b = 0; b < 16; b++) begin
        if (clr[b]) m_stat[b] = 1'b0;
      end
      m_stat = m_stat | {misc, lane_crc_err};
      if (reg_wr && reg_addr == 2'd1) m_en = reg_wdata[15:0] & 16'h3FFF;
      m_irq = pend;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check({cur_req, " irq"}, {31'h0, irq}, {31'h0, m_irq});
      check({cur_req, " rdata"}, reg_rdata, m_rdata);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    v = reg_rdata;
  endtask

  task automatic pulse(input logic [7:0] lanes, input logic [7:0] m);
    lane_crc_err = lanes; misc = m;
    @(negedge clk);
    lane_crc_err = '0; misc = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    check("R1 irq", {31'h0, irq}, 32'h0);
    rd(2'd0, v); check("R1 status", v, 32'h0);
    rd(2'd1, v); check("R1 enable", v, 32'h0);

    // R2 lane errors sticky
    cur_req = "R2";
    pulse(8'h08, 8'h00);
    pulse(8'h80, 8'h00);
    idle(4);
    rd(2'd0, v); check("R2 lanes sticky", v, 32'h0000_0088);

    // R3 single-bit events, each individually
    cur_req = "R3";
    wr(2'd0, 32'h0000_FFFF);
    for (int k = 0; k < 8; k++) begin
      pulse(8'h00, 8'(1 << k));
      rd(2'd0, v); check("R3 event bit", v & 32'h0000_FF00, 32'h0000_FF00 & ((32'h200 << k) - 32'h100));
    end

    // R4 write-one-to-clear
    cur_req = "R4";
    pulse(8'h0F, 8'h00);
    wr(2'd0, 32'h0000_0105);
    rd(2'd0, v); check("R4 partial clear", v, 32'h0000_FE0A);
    wr(2'd0, 32'h0000_0000);
    rd(2'd0, v); check("R4 zero write keeps", v, 32'h0000_FE0A);
    wr(2'd0, 32'h0000_FFFF);
    rd(2'd0, v); check("R4 clear all", v, 32'h0);

    // R5 event beats clear in the same cycle
    cur_req = "R5";
    misc = 8'h02; lane_crc_err = 8'h01;
    wr(2'd0, 32'h0000_0203);
    misc = '0; lane_crc_err = '0;
    rd(2'd0, v); check("R5 event wins", v, 32'h0000_0201);
    wr(2'd0, 32'h0000_FFFF);

    // R6 enable mask
    cur_req = "R6";
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); check("R6 enable readback", v, 32'h0000_3FFF);
    pulse(8'h00, 8'hC0);
    idle(2);
    check("R6 bits 14/15 no irq", {31'h0, irq}, 32'h0);
    wr(2'd0, 32'h0000_FFFF);
    wr(2'd1, 32'h0000_0000);

    // R7 registered interrupt timing
    cur_req = "R7";
    wr(2'd1, 32'h0000_0800);
    pulse(8'h00, 8'h08);
    check("R7 irq not yet", {31'h0, irq}, 32'h0);
    @(negedge clk);
    check("R7 irq raised", {31'h0, irq}, 32'h1);
    wr(2'd0, 32'h0000_0800);
    check("R7 irq held one cycle", {31'h0, irq}, 32'h1);
    @(negedge clk);
    check("R7 irq dropped", {31'h0, irq}, 32'h0);
    wr(2'd1, 32'h0);

    // R8 latched while disabled, then enabled
    cur_req = "R8";
    pulse(8'h00, 8'h20);
    idle(3);
    check("R8 disabled no irq", {31'h0, irq}, 32'h0);
    rd(2'd0, v); check("R8 status latched", v, 32'h0000_2000);
    wr(2'd1, 32'h0000_2000);
    check("R8 irq after enable edge", {31'h0, irq}, 32'h0);
    @(negedge clk);
    check("R8 irq raised", {31'h0, irq}, 32'h1);
    wr(2'd1, 32'h0);
    wr(2'd0, 32'h0000_FFFF);

    // R9 live busy bit
    cur_req = "R9";
    busy = 1;
    rd(2'd0, v); check("R9 busy high", v, 32'h8000_0000);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); check("R9 write no effect", v, 32'h8000_0000);
    busy = 0;
    rd(2'd0, v); check("R9 busy not sticky", v, 32'h0);

    // R10 read addressing and hold
    cur_req = "R10";
    wr(2'd1, 32'h0000_1234);
    pulse(8'h55, 8'h00);
    rd(2'd2, v); check("R10 unmapped addr", v, 32'h0);
    rd(2'd1, v); check("R10 enable read", v, 32'h0000_1234);
    idle(3);
    check("R10 hold", reg_rdata, 32'h0000_1234);
    reg_rd = 1; reg_addr = 2'd0; pulse(8'h00, 8'h01); reg_rd = 0;
    check("R10 pre-edge value", reg_rdata, 32'h0000_0055);
    idle(2);
    finish_run();
  end
endmodule